// File: doc/BRIEF.md
# Zoned Secure Backup Register File

This block holds a bank of 32-bit retention registers behind a single-cycle register-bus slave. Every request carries two attributes, secure and privileged. The block checks each request against the protection zone that holds the addressed register. It checks it as well against two privilege options and a lock that hides the lowest eight registers.

Two programmable boundaries split the bank into three contiguous zones. The lowest zone is for secure requesters only. In the middle zone a non-secure requester may read but not write. The top zone is open to both. A small control word holds the boundaries, a lock bit and a bit that restricts the control registers to secure requesters. A boundary larger than the number of implemented registers is refused. A read-only word reports that number. A blocked read returns zero. A blocked write changes nothing. Both raise a one-cycle error flag.

Top module: `bkz_top`

## Requirements
- R1: After reset every bank register, both boundaries, the lock, the control-secure bit and both privilege bits are zero, so the whole bank is in the open zone and any requester may access it.
- R2: Word address 0 is the zone control word, 1 the privilege word, 2 the read-only size word (bits 7:0 = number of implemented registers), and bank register i sits at word 64+i. Read data and the error flag appear in the cycle after the request. Writes return zero read data. Any other address, a bank index at or above the register count, or a write to the size word is an error.
- R3: Register i is in the low zone if i < boundary2 and i < boundary1. It is in the middle zone if i < boundary2 and i >= boundary1. Otherwise it is in the open zone. A boundary2 of 0 puts every register in the open zone.
- R4: In the low zone secure requests may read and write, and non-secure requests may neither read nor write.
- R5: In the middle zone secure requests may read and write, and non-secure requests may only read.
- R6: In the open zone secure and non-secure requests may both read and write.
- R7: A blocked read returns all zeros. A blocked write leaves the target unchanged. Either one raises the error output for exactly one cycle.
- R8: The control word holds boundary1 in bits 7:0, boundary2 in bits 23:16, the lock in bit 30 and control-secure in bit 31. Only a request that is both secure and privileged may write it. Any other write is an error and changes nothing.
- R9: Each boundary field is validated on its own. A value above the register count keeps the old value of that field, and the other fields of the same write still take effect without an error. A value equal to the count is accepted.
- R10: Privilege word bit 29 set: low-zone and middle-zone accesses need a privileged request. Bit 30 set: open-zone writes need a privileged request. Writing the privilege word needs a privileged request.
- R11: While control-secure is set, a non-secure request to read the control word, or to read or write the privilege word, is blocked.
- R12: While the lock is set, bank registers 0 to 7 read as zero and ignore writes for every requester, each such access being an error. Once set, the lock clears only on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_en | input | 1 | Request valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_sec | input | 1 | Requester is secure |
| bus_priv | input | 1 | Requester is privileged |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_err | output | 1 | One-cycle pulse for a blocked or unmapped request |

## Verification
Boundary validation and the lock fall in the same cycle when one control-word write carries an out-of-range boundary1 together with the lock bit. The bench issues that write and then reads the control word back. It expects the old boundary1, the new boundary2 and the lock set, with no error on the write. The lock window and the zone check also meet on one access: a read of register 5 lies in the middle zone and inside the lock window. The bench expects the lock to win, with zero data and an error even for a secure, privileged requester.

// File: rtl/bkz_pkg.sv
package bkz_pkg;

  typedef enum logic [1:0] {
    ZN_NONE = 2'd0,
    ZN_LOW  = 2'd1,
    ZN_MID  = 2'd2,
    ZN_OPEN = 2'd3
  } zone_e;

  typedef struct packed {
    logic we;
    logic sec;
    logic priv;
  } attr_t;

  localparam int CFG_B1_LSB    = 0;
  localparam int CFG_B2_LSB    = 16;
  localparam int CFG_LOCK_BIT  = 30;
  localparam int CFG_CSEC_BIT  = 31;
  localparam int PRV_LOW_BIT   = 29;
  localparam int PRV_OPENW_BIT = 30;
  localparam int LOCKED_REGS   = 8;

endpackage

// File: rtl/bkz_zone_map.sv
module bkz_zone_map
  import bkz_pkg::*;
#(
  parameter int BND_W = 8
) (
  input  logic [BND_W-1:0] idx,
  input  logic [BND_W-1:0] bound1,
  input  logic [BND_W-1:0] bound2,
  output zone_e            zone
);

  always_comb begin
    if (idx < bound2) begin
      if (idx < bound1) zone = ZN_LOW;
      else              zone = ZN_MID;
    end else begin
      zone = ZN_OPEN;
    end
  end

endmodule

// File: rtl/bkz_perm.sv
module bkz_perm
  import bkz_pkg::*;
(
  input  zone_e zone,
  input  attr_t attr,
  input  logic  lock_hit,
  input  logic  low_need_priv,
  input  logic  open_wr_need_priv,
  output logic  allow
);

  logic base_ok;
  logic priv_ok;

  always_comb begin
    unique case (zone)
      ZN_LOW:  base_ok = attr.sec;
      ZN_MID:  base_ok = attr.sec || !attr.we;
      ZN_OPEN: base_ok = 1'b1;
      default: base_ok = 1'b0;
    endcase
  end

  always_comb begin
    priv_ok = 1'b1;
    if ((zone == ZN_LOW || zone == ZN_MID) && low_need_priv)
      priv_ok = attr.priv;
    else if (zone == ZN_OPEN && attr.we && open_wr_need_priv)
      priv_ok = attr.priv;
  end

  assign allow = !lock_hit && base_ok && priv_ok;

endmodule

// File: rtl/bkz_cfg.sv
module bkz_cfg
  import bkz_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int BND_W    = 8,
  parameter int DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              prv_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [BND_W-1:0]  bound1,
  output logic [BND_W-1:0]  bound2,
  output logic              lock,
  output logic              ctl_sec,
  output logic              low_priv,
  output logic              open_wr_priv,
  output logic [DATA_W-1:0] cfg_word,
  output logic [DATA_W-1:0] prv_word
);

  localparam logic [BND_W-1:0] MAX_BND = BND_W'(NUM_REGS);

  logic [BND_W-1:0] b1_q, b1_d, b2_q, b2_d;
  logic             lock_q, lock_d, csec_q, csec_d;
  logic             lowp_q, lowp_d, openp_q, openp_d;
  logic [BND_W-1:0] w_b1, w_b2;
  logic             unused_wbits;

  assign w_b1 = wdata[CFG_B1_LSB +: BND_W];
  assign w_b2 = wdata[CFG_B2_LSB +: BND_W];
  assign unused_wbits = ^{wdata[29:24], wdata[15:8]};

  always_comb begin
    b1_d    = b1_q;
    b2_d    = b2_q;
    lock_d  = lock_q;
    csec_d  = csec_q;
    lowp_d  = lowp_q;
    openp_d = openp_q;
    if (cfg_wr) begin
      if (w_b1 <= MAX_BND) b1_d = w_b1;
      if (w_b2 <= MAX_BND) b2_d = w_b2;
      lock_d = lock_q | wdata[CFG_LOCK_BIT];
      csec_d = wdata[CFG_CSEC_BIT];
    end
    if (prv_wr) begin
      lowp_d  = wdata[PRV_LOW_BIT];
      openp_d = wdata[PRV_OPENW_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b1_q    <= '0;
      b2_q    <= '0;
      lock_q  <= 1'b0;
      csec_q  <= 1'b0;
      lowp_q  <= 1'b0;
      openp_q <= 1'b0;
    end else begin
      b1_q    <= b1_d;
      b2_q    <= b2_d;
      lock_q  <= lock_d;
      csec_q  <= csec_d;
      lowp_q  <= lowp_d;
      openp_q <= openp_d;
    end
  end

  assign bound1       = b1_q;
  assign bound2       = b2_q;
  assign lock         = lock_q;
  assign ctl_sec      = csec_q;
  assign low_priv     = lowp_q;
  assign open_wr_priv = openp_q;

  always_comb begin
    cfg_word = '0;
    cfg_word[CFG_B1_LSB +: BND_W] = b1_q;
    cfg_word[CFG_B2_LSB +: BND_W] = b2_q;
    cfg_word[CFG_LOCK_BIT]        = lock_q;
    cfg_word[CFG_CSEC_BIT]        = csec_q;
    prv_word = '0;
    prv_word[PRV_LOW_BIT]         = lowp_q;
    prv_word[PRV_OPENW_BIT]       = openp_q;
  end

endmodule

// File: rtl/bkz_store.sv
module bkz_store #(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
    logic hit;
    assign hit = wr_en && (idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem[g] <= '0;
      else if (hit) mem[g] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < NUM_REGS; k++)
      if (idx == IDX_W'(k)) rdata = mem[k];
  end

endmodule

// File: rtl/bkz_top.sv
module bkz_top
  import bkz_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 32,
  parameter int BND_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_sec,
  input  logic              bus_priv,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_err
);

  localparam int OFF_W = ADDR_W - 1;
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [OFF_W-1:0] A_CFG = OFF_W'(0);
  localparam logic [OFF_W-1:0] A_PRV = OFF_W'(1);
  localparam logic [OFF_W-1:0] A_CNT = OFF_W'(2);
  localparam logic [BND_W-1:0] CNT_V = BND_W'(NUM_REGS);

  // reset: asserted asynchronously, released after two clock edges
  logic rst_s1_n, rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_n <= 1'b0;
      rst_q_n  <= 1'b0;
    end else begin
      rst_s1_n <= 1'b1;
      rst_q_n  <= rst_s1_n;
    end
  end

  // decode
  logic             is_bank, bank_hit, is_cfg, is_prv, is_cnt;
  logic [OFF_W-1:0] off;
  logic [BND_W-1:0] off_ext;
  logic             lock_win;
  attr_t            attr;

  assign is_bank  = bus_addr[ADDR_W-1];
  assign off      = bus_addr[OFF_W-1:0];
  assign off_ext  = BND_W'(off);
  assign bank_hit = is_bank && (off_ext < CNT_V);
  assign is_cfg   = !is_bank && (off == A_CFG);
  assign is_prv   = !is_bank && (off == A_PRV);
  assign is_cnt   = !is_bank && (off == A_CNT);
  assign attr     = '{we: bus_we, sec: bus_sec, priv: bus_priv};

  // configuration
  logic [BND_W-1:0]  bound1, bound2;
  logic              lock_q, ctl_sec, low_priv, open_wr_priv;
  logic [DATA_W-1:0] cfg_word, prv_word;
  logic              cfg_wr, prv_wr, ctl_ok;

  assign ctl_ok = !ctl_sec || bus_sec;
  assign cfg_wr = bus_en && bus_we && is_cfg && bus_sec && bus_priv;
  assign prv_wr = bus_en && bus_we && is_prv && bus_priv && ctl_ok;

  bkz_cfg #(.NUM_REGS(NUM_REGS), .BND_W(BND_W), .DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst_n(rst_q_n), .cfg_wr(cfg_wr), .prv_wr(prv_wr),
    .wdata(bus_wdata), .bound1(bound1), .bound2(bound2), .lock(lock_q),
    .ctl_sec(ctl_sec), .low_priv(low_priv), .open_wr_priv(open_wr_priv),
    .cfg_word(cfg_word), .prv_word(prv_word)
  );

  // zone and permission
  zone_e zone;
  logic  bank_allow;

  assign lock_win = lock_q && (off_ext < BND_W'(LOCKED_REGS));

  bkz_zone_map #(.BND_W(BND_W)) u_zone (
    .idx(off_ext), .bound1(bound1), .bound2(bound2), .zone(zone)
  );

  bkz_perm u_perm (
    .zone(zone), .attr(attr), .lock_hit(lock_win),
    .low_need_priv(low_priv), .open_wr_need_priv(open_wr_priv),
    .allow(bank_allow)
  );

  // storage
  logic [DATA_W-1:0] bank_rd;
  logic              bank_wr;

  assign bank_wr = bus_en && bus_we && bank_hit && bank_allow;

  bkz_store #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_q_n), .wr_en(bank_wr), .idx(off[IDX_W-1:0]),
    .wdata(bus_wdata), .rdata(bank_rd)
  );

  // response
  logic              ok;
  logic [DATA_W-1:0] rd_val;

  always_comb begin
    ok     = 1'b0;
    rd_val = '0;
    if (bank_hit) begin
      ok     = bank_allow;
      rd_val = bank_rd;
    end else if (is_cfg) begin
      ok     = bus_we ? (bus_sec && bus_priv) : ctl_ok;
      rd_val = cfg_word;
    end else if (is_prv) begin
      ok     = bus_we ? (bus_priv && ctl_ok) : ctl_ok;
      rd_val = prv_word;
    end else if (is_cnt) begin
      ok     = !bus_we;
      rd_val = DATA_W'(CNT_V);
    end
  end

  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              err_q, err_d;

  always_comb begin
    rdata_d = rdata_q;
    err_d   = 1'b0;
    if (bus_en) begin
      err_d   = !ok;
      rdata_d = (!bus_we && ok) ? rd_val : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      rdata_q <= rdata_d;
      err_q   <= err_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign bus_err   = err_q;

endmodule

// File: rtl/bkz_checker.sv
module bkz_checker
  import bkz_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  parameter int BND_W    = 8
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic              bus_en,
  input logic              bus_we,
  input logic              bus_sec,
  input logic              bus_priv,
  input logic              is_cfg,
  input logic              bank_hit,
  input logic              lock_win,
  input zone_e             zone,
  input logic              lock_q,
  input logic [BND_W-1:0]  bound1,
  input logic [BND_W-1:0]  bound2,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_err
);

  a_r7_err_reads_zero: assert property (@(posedge clk) disable iff (!rst_q_n)
    bus_err |-> (bus_rdata == '0));

  a_r9_bounds_in_range: assert property (@(posedge clk) disable iff (!rst_q_n)
    (bound1 <= BND_W'(NUM_REGS)) && (bound2 <= BND_W'(NUM_REGS)));

  a_r12_lock_sticky: assert property (@(posedge clk) disable iff (!rst_q_n)
    lock_q |=> lock_q);

  a_r12_lock_window_blocked: assert property (@(posedge clk) disable iff (!rst_q_n)
    (bus_en && bank_hit && lock_win) |=> (bus_err && bus_rdata == '0));

  a_r4_low_nonsec_blocked: assert property (@(posedge clk) disable iff (!rst_q_n)
    (bus_en && bank_hit && zone == ZN_LOW && !bus_sec) |=> bus_err);

  a_r5_mid_nonsec_write_blocked: assert property (@(posedge clk) disable iff (!rst_q_n)
    (bus_en && bus_we && bank_hit && zone == ZN_MID && !bus_sec) |=> bus_err);

  a_r8_cfg_write_guard: assert property (@(posedge clk) disable iff (!rst_q_n)
    (bus_en && bus_we && is_cfg && !(bus_sec && bus_priv)) |=> bus_err);

endmodule

bind bkz_top bkz_checker #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .BND_W(BND_W)) u_chk (
  .clk(clk), .rst_q_n(rst_q_n), .bus_en(bus_en), .bus_we(bus_we),
  .bus_sec(bus_sec), .bus_priv(bus_priv), .is_cfg(is_cfg),
  .bank_hit(bank_hit), .lock_win(lock_win), .zone(zone), .lock_q(lock_q),
  .bound1(bound1), .bound2(bound2), .bus_rdata(bus_rdata), .bus_err(bus_err)
);

// File: tb/tb_bkz_top.sv
`timescale 1ns/1ps
module tb_bkz_top;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 7;

  logic              clk;
  logic              rst_n;
  logic              bus_en, bus_we, bus_sec, bus_priv;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata;
  logic [DATA_W-1:0] bus_rdata;
  logic              bus_err;

  bkz_top dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_sec(bus_sec),
    .bus_priv(bus_priv), .bus_rdata(bus_rdata), .bus_err(bus_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct {
    logic [DATA_W-1:0] rd;
    logic              er;
    string             tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_run  = 0;
  int   n_fail = 0;
  bit   done   = 0;

  localparam logic [ADDR_W-1:0] CFG = 7'd0;
  localparam logic [ADDR_W-1:0] PRV = 7'd1;
  localparam logic [ADDR_W-1:0] CNT = 7'd2;
  function automatic logic [ADDR_W-1:0] bk(int i);
    return ADDR_W'(64 + i);
  endfunction

  task automatic check(string tag, logic [DATA_W-1:0] got_rd, logic got_er,
                       logic [DATA_W-1:0] want_rd, logic want_er);
    n_run++;
    if (got_rd !== want_rd || got_er !== want_er) begin
      n_fail++;
      $display("FAIL %s: rdata=%h err=%b expected rdata=%h err=%b",
               tag, got_rd, got_er, want_rd, want_er);
    end
  endtask

  // driver: one request per call, expected response pushed to the scoreboard
  task automatic acc(logic we, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] wd,
                     logic s, logic p, logic [DATA_W-1:0] erd, logic eer, string tag);
    exp_t e;
    @(negedge clk);
    bus_en = 1'b1; bus_we = we; bus_addr = a; bus_wdata = wd;
    bus_sec = s; bus_priv = p;
    e.rd = erd; e.er = eer; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      if (bus_en) begin
        exp_t e;
        @(negedge clk);
        e = exp_q.pop_front();
        check(e.tag, bus_rdata, bus_err, e.rd, e.er);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected completion", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    bus_en = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0; bus_sec = 0; bus_priv = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 reset outputs", bus_rdata, bus_err, '0, 1'b0);

    acc(0, CNT, 0, 0, 0, 32'd32, 0, "R2 size word");
    acc(0, CFG, 0, 0, 0, 32'h0, 0, "R1 control zero");
    acc(0, bk(0), 0, 0, 0, 32'h0, 0, "R1 bank zero open");
    acc(1, bk(0), 32'hA5A50001, 0, 0, 32'h0, 0, "R6 nonsec write open");
    acc(0, bk(0), 0, 0, 0, 32'hA5A50001, 0, "R6 nonsec read open");

    acc(1, CFG, 32'h000A0004, 0, 1, 32'h0, 1, "R8 nonsec cfg write");
    acc(1, CFG, 32'h000A0004, 1, 0, 32'h0, 1, "R8 unpriv cfg write");
    acc(0, CFG, 0, 1, 1, 32'h0, 0, "R8 cfg unchanged");
    acc(1, CFG, 32'h000A0004, 1, 1, 32'h0, 0, "R8 cfg write");
    acc(0, CFG, 0, 1, 1, 32'h000A0004, 0, "R8 cfg layout");

    acc(1, bk(2), 32'h11112222, 1, 1, 32'h0, 0, "R4 sec write low");
    acc(0, bk(2), 0, 0, 1, 32'h0, 1, "R4 nonsec read low");
    acc(1, bk(2), 32'hDEAD0000, 0, 1, 32'h0, 1, "R4 nonsec write low");
    acc(0, bk(2), 0, 1, 1, 32'h11112222, 0, "R7 blocked write no change");

    acc(1, bk(5), 32'h33334444, 1, 1, 32'h0, 0, "R5 sec write mid");
    acc(0, bk(5), 0, 0, 1, 32'h33334444, 0, "R5 nonsec read mid");
    acc(1, bk(5), 32'h0BAD0BAD, 0, 1, 32'h0, 1, "R5 nonsec write mid");
    acc(0, bk(5), 0, 1, 1, 32'h33334444, 0, "R5 mid unchanged");

    acc(1, bk(4), 32'h00000044, 1, 1, 32'h0, 0, "R3 sec write idx4");
    acc(0, bk(4), 0, 0, 1, 32'h00000044, 0, "R3 first mid index");
    acc(0, bk(3), 0, 0, 1, 32'h0, 1, "R3 last low index");
    acc(1, bk(9), 32'h9, 0, 1, 32'h0, 1, "R3 last mid index");
    acc(1, bk(10), 32'h1010, 0, 0, 32'h0, 0, "R3 first open index");
    acc(0, bk(10), 0, 0, 0, 32'h1010, 0, "R3 open readback");

    acc(1, CFG, 32'h00210028, 1, 1, 32'h0, 0, "R9 oversize write no error");
    acc(0, CFG, 0, 1, 1, 32'h000A0004, 0, "R9 oversize kept");
    acc(1, CFG, 32'h00200020, 1, 1, 32'h0, 0, "R9 equal count write");
    acc(0, CFG, 0, 1, 1, 32'h00200020, 0, "R9 equal count accepted");
    acc(0, bk(31), 0, 0, 1, 32'h0, 1, "R3 whole bank low");
    acc(1, CFG, 32'h00000006, 1, 1, 32'h0, 0, "R3 boundary2 zero write");
    acc(0, bk(2), 0, 0, 0, 32'h11112222, 0, "R3 boundary2 zero all open");

    acc(1, CFG, 32'h000A0004, 1, 1, 32'h0, 0, "R10 restore map");
    acc(1, PRV, 32'h20000000, 1, 1, 32'h0, 0, "R10 set low priv");
    acc(0, PRV, 0, 1, 1, 32'h20000000, 0, "R10 prv readback");
    acc(0, bk(2), 0, 1, 0, 32'h0, 1, "R10 unpriv low read");
    acc(0, bk(5), 0, 0, 0, 32'h0, 1, "R10 unpriv mid read");
    acc(0, bk(5), 0, 0, 1, 32'h33334444, 0, "R10 priv mid read");
    acc(1, bk(10), 32'h2020, 0, 0, 32'h0, 0, "R10 open write unaffected");
    acc(1, PRV, 32'h60000000, 1, 1, 32'h0, 0, "R10 set open write priv");
    acc(1, bk(10), 32'h3030, 0, 0, 32'h0, 1, "R10 unpriv open write");
    acc(0, bk(10), 0, 0, 0, 32'h2020, 0, "R10 unpriv open read");
    acc(1, PRV, 32'h0, 0, 0, 32'h0, 1, "R10 unpriv prv write");
    acc(0, PRV, 0, 0, 0, 32'h60000000, 0, "R10 prv kept");

    acc(1, CFG, 32'h800A0004, 1, 1, 32'h0, 0, "R11 set ctl secure");
    acc(0, CFG, 0, 0, 1, 32'h0, 1, "R11 nonsec cfg read");
    acc(0, PRV, 0, 0, 1, 32'h0, 1, "R11 nonsec prv read");
    acc(1, PRV, 32'h0, 0, 1, 32'h0, 1, "R11 nonsec prv write");
    acc(0, PRV, 0, 1, 1, 32'h60000000, 0, "R11 prv unchanged");
    acc(1, PRV, 32'h0, 1, 1, 32'h0, 0, "R10 clear prv");

    acc(1, CFG, 32'hC00A0032, 1, 1, 32'h0, 0, "R12 lock with bad boundary");
    acc(0, CFG, 0, 1, 1, 32'hC00A0004, 0, "R9 R12 mixed write");
    acc(0, bk(2), 0, 1, 1, 32'h0, 1, "R12 locked read");
    acc(1, bk(2), 32'h9999, 1, 1, 32'h0, 1, "R12 locked write");
    acc(0, bk(5), 0, 1, 1, 32'h0, 1, "R12 lock beats mid zone");
    acc(0, bk(10), 0, 0, 0, 32'h2020, 0, "R12 above window");
    acc(1, CFG, 32'h000A0004, 1, 1, 32'h0, 0, "R12 try unlock");
    acc(0, CFG, 0, 1, 1, 32'h400A0004, 0, "R12 lock sticky");

    acc(0, 7'd100, 0, 1, 1, 32'h0, 1, "R2 index beyond count");
    acc(0, 7'd3, 0, 1, 1, 32'h0, 1, "R2 unmapped control");
    acc(1, CNT, 32'h5, 1, 1, 32'h0, 1, "R2 size write");
    acc(0, CNT, 0, 1, 1, 32'd32, 0, "R2 size unchanged");

    do_reset();
    acc(0, CFG, 0, 1, 1, 32'h0, 0, "R1 lock cleared by reset");
    acc(0, bk(5), 0, 0, 0, 32'h0, 0, "R1 bank cleared");
    acc(0, bk(10), 0, 0, 0, 32'h0, 0, "R1 open bank cleared");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_run++;
      n_fail++;
      $display("FAIL scoreboard: pending=%0d expected 0", exp_q.size());
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule